// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the datapath of a small 32-bit processor that finishes each instruction over several clock cycles. It owns the program counter, an instruction latch, two operand latches, a result latch, a memory-read latch, a 32-entry register file, one shared adder/subtractor and the next-PC selection. An external sequencer sets a bundle of strobes on every cycle and so decides what happens. The block does not hold that sequence itself.

A single shared ALU and a single unified memory port serve every phase of an instruction: fetch, decode, execute, memory access and write-back. Any value that one cycle computes and a later cycle consumes is stored in a holding register. Without it the value would be lost at the clock edge. The memory array lives outside the block and is reached through an address, write-data, read-data and write-enable port.

Top module: `mcdp_core`

## Requirements
- R1: After reset is asserted (`rstN` low), the PC, the instruction latch, both operand latches, the result latch, the memory-read latch and every register-file entry read as zero.
- R2: The instruction latch takes all 32 bits of `memRdata` on an edge where `irWrite` is high. Otherwise it holds its value.
- R3: The ALU computes srcA + srcB, or srcA − srcB when `aluSub` is high. srcA is the PC when `aluSrcA`=0 and operand A when it is 1. srcB is selected by `aluSrcB`: 0 gives operand B, 1 gives the constant 4, 2 gives the extended immediate, 3 gives the extended immediate shifted left by two. The result latch takes the ALU output on every edge.
- R4: The immediate is instruction bits 15:0. Bit 15 is copied into bits 31:16, so negative offsets subtract.
- R5: The PC source is selected by `pcSrc`: 0 gives the live ALU output, 1 gives the result latch, 2 gives the jump address {PC[31:28], instr[25:0], 2'b00}.
- R6: The PC is written when `pcWrite` is high, or when `pcWriteCond` is high and the live ALU output is zero. In every other case it holds.
- R7: Operand A takes the register addressed by instr[25:21] on every edge, and operand B takes the register addressed by instr[20:16]. `memWdata` always carries operand B.
- R8: `memAddr` is the PC when `iorD`=0 and the result latch when `iorD`=1. `memWe` follows `memWrite`.
- R9: The memory-read latch takes `memRdata` on every edge.
- R10: When `regWrite` is high, the register given by instr[15:11] (`regDst`=1) or by instr[20:16] (`regDst`=0) is written at the edge. The data is the memory-read latch (`memToReg`=1) or the result latch (`memToReg`=0). A read in the next cycle sees the new value.
- R11: Register 0 always reads as zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pcWrite | input | 1 | Unconditional PC write |
| pcWriteCond | input | 1 | PC write when ALU output is zero |
| iorD | input | 1 | Memory address select (0 PC, 1 result latch) |
| memWrite | input | 1 | Memory store strobe |
| irWrite | input | 1 | Instruction latch load |
| regWrite | input | 1 | Register file write |
| regDst | input | 1 | Write destination select |
| memToReg | input | 1 | Write-back data select |
| aluSrcA | input | 1 | ALU first operand select |
| aluSrcB | input | 2 | ALU second operand select |
| aluSub | input | 1 | Subtract instead of add |
| pcSrc | input | 2 | Next PC source select |
| memAddr | output | 32 | Unified memory address |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Load / fetch data |
| memWe | output | 1 | Memory write enable |

## Verification
The hardest situation to reach is the conditional PC write. It depends on a zero flag computed from two register values that were placed in the register file several cycles earlier, through a load into the memory-read latch and a write-back. The stimulus builds both the equal and the unequal register pairs this way. It first precomputes a branch target in the result latch, then runs the compare with and without the conditional strobe. Showing that a jump keeps the PC's top nibble also needs a PC with nonzero top bits. The bench gets one by routing a register value through operand A and the result latch into the PC.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  localparam int XLEN = 32;
  localparam int REG_CNT = 32;
  localparam int REG_AW = $clog2(REG_CNT);

  localparam logic [1:0] SRCB_REG  = 2'd0;
  localparam logic [1:0] SRCB_FOUR = 2'd1;
  localparam logic [1:0] SRCB_IMM  = 2'd2;
  localparam logic [1:0] SRCB_OFS  = 2'd3;

  localparam logic [1:0] PCSEL_ALU  = 2'd0;
  localparam logic [1:0] PCSEL_HOLD = 2'd1;
  localparam logic [1:0] PCSEL_JUMP = 2'd2;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       iorD;
    logic       memWrite;
    logic       irWrite;
    logic       regWrite;
    logic       regDst;
    logic       memToReg;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic       aluSub;
    logic [1:0] pcSrc;
  } ctlBundle_t;
endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_CNT = 32,
  localparam int AW = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     rAddrA,
  input  logic [AW-1:0]     rAddrB,
  output logic [DATA_W-1:0] rDataA,
  output logic [DATA_W-1:0] rDataB,
  input  logic              wEn,
  input  logic [AW-1:0]     wAddr,
  input  logic [DATA_W-1:0] wData
);
  logic [DATA_W-1:0] regs [REG_CNT];

  // entry 0 is cleared by reset and never written afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (wEn && (wAddr != '0)) begin
      regs[wAddr] <= wData;
    end
  end

  assign rDataA = regs[rAddrA];
  assign rDataB = regs[rAddrB];

  // R11: entry zero reads zero on both ports
  a_r11_zero_reads: assert property (@(posedge clk) disable iff (!rstN)
    ((rAddrA == '0) |-> (rDataA == '0)) and ((rAddrB == '0) |-> (rDataB == '0)));

  // R10: a write lands at the edge
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wEn && (wAddr != '0)) |=> (regs[$past(wAddr)] == $past(wData)));
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             sub,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  always_comb begin
    if (sub) result = opA - opB;
    else     result = opA + opB;
  end
  assign zero = (result == '0);
endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
  import mcdp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlBundle_t        ctl,
  input  logic [XLEN-1:0]   memRdata,
  input  logic [XLEN-1:0]   aluResult,
  input  logic              aluZero,
  input  logic [XLEN-1:0]   rfDataA,
  input  logic [XLEN-1:0]   rfDataB,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   memWdata,
  output logic              memWe,
  output logic [XLEN-1:0]   aluOpA,
  output logic [XLEN-1:0]   aluOpB,
  output logic [REG_AW-1:0] rfAddrA,
  output logic [REG_AW-1:0] rfAddrB,
  output logic [REG_AW-1:0] rfWAddr,
  output logic [XLEN-1:0]   rfWData,
  output logic              rfWEn
);
  logic [XLEN-1:0] pc, ir, opRegA, opRegB, aluOut, mdr;
  logic [XLEN-1:0] immExt, immOfs, jumpAddr, pcNext;
  logic            pcEn;
  logic            unusedOpcode;

  assign unusedOpcode = ^ir[31:26];

  assign immExt   = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign immOfs   = {immExt[XLEN-3:0], 2'b00};
  assign jumpAddr = {pc[XLEN-1:XLEN-4], ir[25:0], 2'b00};

  assign rfAddrA = ir[25:21];
  assign rfAddrB = ir[20:16];
  assign rfWAddr = ctl.regDst ? ir[15:11] : ir[20:16];
  assign rfWData = ctl.memToReg ? mdr : aluOut;
  assign rfWEn   = ctl.regWrite;

  assign aluOpA = ctl.aluSrcA ? opRegA : pc;
  always_comb begin
    unique case (ctl.aluSrcB)
      SRCB_REG:  aluOpB = opRegB;
      SRCB_FOUR: aluOpB = XLEN'(4);
      SRCB_IMM:  aluOpB = immExt;
      default:   aluOpB = immOfs;
    endcase
  end

  always_comb begin
    case (ctl.pcSrc)
      PCSEL_HOLD: pcNext = aluOut;
      PCSEL_JUMP: pcNext = jumpAddr;
      default:    pcNext = aluResult;
    endcase
  end
  assign pcEn = ctl.pcWrite | (ctl.pcWriteCond & aluZero);

  assign memAddr  = ctl.iorD ? aluOut : pc;
  assign memWdata = opRegB;
  assign memWe    = ctl.memWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
      ir <= '0;
    end else begin
      if (pcEn)        pc <= pcNext;
      if (ctl.irWrite) ir <= memRdata;
    end
  end

  // holding registers load on every edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opRegA <= '0;
      opRegB <= '0;
      aluOut <= '0;
      mdr    <= '0;
    end else begin
      opRegA <= rfDataA;
      opRegB <= rfDataB;
      aluOut <= aluResult;
      mdr    <= memRdata;
    end
  end

  // R2: instruction latch holds without its strobe
  a_r2_ir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.irWrite |=> $stable(ir));

  // R6: no write strobe qualifies, so PC holds
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.pcWrite && !(ctl.pcWriteCond && aluZero)) |=> $stable(pc));

  // R6: taken conditional write from the result latch
  a_r6_branch_taken: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcWriteCond && aluZero && ctl.pcSrc == PCSEL_HOLD) |=> (pc == $past(aluOut)));

  // R5: jump keeps the top nibble and word alignment
  a_r5_jump_shape: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcWrite && ctl.pcSrc == PCSEL_JUMP) |=>
      (pc[1:0] == 2'b00 && pc[XLEN-1:XLEN-4] == $past(pc[XLEN-1:XLEN-4])));

  // R3: fetch increment advances the PC by four
  a_r3_pc_plus4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcWrite && ctl.pcSrc == PCSEL_ALU && !ctl.aluSrcA &&
     ctl.aluSrcB == SRCB_FOUR && !ctl.aluSub) |=> (pc == $past(pc) + XLEN'(4)));
endmodule

// File: rtl/mcdp_core.sv
module mcdp_core
  import mcdp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pcWrite,
  input  logic        pcWriteCond,
  input  logic        iorD,
  input  logic        memWrite,
  input  logic        irWrite,
  input  logic        regWrite,
  input  logic        regDst,
  input  logic        memToReg,
  input  logic        aluSrcA,
  input  logic [1:0]  aluSrcB,
  input  logic        aluSub,
  input  logic [1:0]  pcSrc,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic        memWe
);
  ctlBundle_t        ctl;
  logic [XLEN-1:0]   aluOpA, aluOpB, aluResult, rfDataA, rfDataB, rfWData;
  logic              aluZero, rfWEn;
  logic [REG_AW-1:0] rfAddrA, rfAddrB, rfWAddr;

  assign ctl = '{pcWrite: pcWrite, pcWriteCond: pcWriteCond, iorD: iorD,
                 memWrite: memWrite, irWrite: irWrite, regWrite: regWrite,
                 regDst: regDst, memToReg: memToReg, aluSrcA: aluSrcA,
                 aluSrcB: aluSrcB, aluSub: aluSub, pcSrc: pcSrc};

  mcdp_datapath i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata),
    .aluResult(aluResult), .aluZero(aluZero),
    .rfDataA(rfDataA), .rfDataB(rfDataB),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .aluOpA(aluOpA), .aluOpB(aluOpB),
    .rfAddrA(rfAddrA), .rfAddrB(rfAddrB),
    .rfWAddr(rfWAddr), .rfWData(rfWData), .rfWEn(rfWEn)
  );

  mcdp_alu #(.WIDTH(XLEN)) i_alu (
    .opA(aluOpA), .opB(aluOpB), .sub(ctl.aluSub),
    .result(aluResult), .zero(aluZero)
  );

  mcdp_regfile #(.DATA_W(XLEN), .REG_CNT(REG_CNT)) i_regfile (
    .clk(clk), .rstN(rstN),
    .rAddrA(rfAddrA), .rAddrB(rfAddrB),
    .rDataA(rfDataA), .rDataB(rfDataB),
    .wEn(rfWEn), .wAddr(rfWAddr), .wData(rfWData)
  );
endmodule

// File: tb/test_mcdp_core.sv
`timescale 1ns/1ps
module test_mcdp_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pcWrite, pcWriteCond, iorD, memWrite, irWrite, regWrite;
  logic        regDst, memToReg, aluSrcA, aluSub;
  logic [1:0]  aluSrcB, pcSrc;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memWe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] expPc = 32'h0;
  logic [31:0] gotA, gotB;

  always #2.5 clk = ~clk;

  mcdp_core i_mcdp_core (
    .clk(clk), .rstN(rstN), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
    .iorD(iorD), .memWrite(memWrite), .irWrite(irWrite), .regWrite(regWrite),
    .regDst(regDst), .memToReg(memToReg), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB),
    .aluSub(aluSub), .pcSrc(pcSrc), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe)
  );

  function automatic logic [31:0] iFmt(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] rFmt(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {6'h00, rs, rt, rd, 11'h020};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    pcWrite = 0; pcWriteCond = 0; iorD = 0; memWrite = 0; irWrite = 0;
    regWrite = 0; regDst = 0; memToReg = 0; aluSrcA = 0; aluSrcB = 2'd0;
    aluSub = 0; pcSrc = 2'd0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic loadIr(logic [31:0] instr);
    clr(); memRdata = instr; irWrite = 1; tick(); clr();
  endtask

  task automatic writeReg(logic [4:0] r, logic [31:0] val);
    loadIr(iFmt(6'h23, 5'd0, r, 16'h0));
    memRdata = val; tick();
    regWrite = 1; memToReg = 1; regDst = 0; tick(); clr();
  endtask

  // A ends up in the result latch, B on memWdata
  task automatic readRegs(logic [4:0] rs, logic [4:0] rt);
    loadIr(iFmt(6'h23, rs, rt, 16'h0));
    tick();
    aluSrcA = 1; aluSrcB = 2'd2; tick(); clr();
    iorD = 1; #1;
    gotA = memAddr; gotB = memWdata;
    iorD = 0; #1;
  endtask

  task automatic tReset();
    #1;
    check("R1 pc", memAddr, 32'h0);
    check("R1 opB", memWdata, 32'h0);
    iorD = 1; #1;
    check("R1 aluOut", memAddr, 32'h0);
    iorD = 0; #1;
    readRegs(5'd5, 5'd6);
    check("R1 reg5", gotA, 32'h0);
    check("R1 reg6", gotB, 32'h0);
  endtask

  task automatic tFetch();
    for (int k = 0; k < 2; k++) begin
      clr(); memRdata = 32'h8C22_0000; irWrite = 1; pcWrite = 1; aluSrcB = 2'd1;
      tick(); clr(); #1;
      expPc = expPc + 4;
      check("R5 R3 fetch pc+4", memAddr, expPc);
    end
    clr(); memWrite = 1; #1;
    check("R8 memWe high", {31'h0, memWe}, 32'h1);
    memWrite = 0; #1;
    check("R8 memWe low", {31'h0, memWe}, 32'h0);
  endtask

  task automatic tImmHold();
    loadIr(iFmt(6'h23, 5'd0, 5'd0, 16'hFFF0));
    memRdata = 32'h0000_7777;
    repeat (3) tick();
    aluSrcB = 2'd2; tick(); clr();
    iorD = 1; #1;
    check("R4 R2 neg imm held", memAddr, expPc - 32'd16);
    iorD = 0; aluSrcB = 2'd3; tick(); clr();
    iorD = 1; #1;
    check("R4 R3 shifted neg imm", memAddr, expPc - 32'd64);
    loadIr(iFmt(6'h23, 5'd0, 5'd0, 16'h0010));
    aluSrcB = 2'd3; tick(); clr();
    iorD = 1; #1;
    check("R4 shifted pos imm", memAddr, expPc + 32'd64);
    iorD = 0; #1;
  endtask

  task automatic tRegs();
    writeReg(5'd3, 32'h1234_5678);
    writeReg(5'd4, 32'h0000_1111);
    readRegs(5'd3, 5'd4);
    check("R7 R9 R10 opA reg3", gotA, 32'h1234_5678);
    check("R7 R9 R10 opB reg4", gotB, 32'h0000_1111);
    loadIr(rFmt(5'd3, 5'd4, 5'd9));
    tick();
    aluSrcA = 1; aluSrcB = 2'd0; tick(); clr();
    regWrite = 1; regDst = 1; memToReg = 0; tick(); clr();
    readRegs(5'd9, 5'd4);
    check("R10 rd gets sum", gotA, 32'h1234_6789);
    check("R10 rt untouched", gotB, 32'h0000_1111);
    loadIr(rFmt(5'd3, 5'd4, 5'd0));
    tick();
    aluSrcA = 1; aluSub = 1; tick(); clr();
    iorD = 1; #1;
    check("R3 subtract", memAddr, 32'h1234_4567);
    iorD = 0; aluSrcA = 1; aluSrcB = 2'd1; tick(); clr();
    iorD = 1; #1;
    check("R3 A plus four", memAddr, 32'h1234_567C);
    iorD = 0; #1;
  endtask

  task automatic tReg0();
    writeReg(5'd0, 32'hDEAD_BEEF);
    readRegs(5'd0, 5'd3);
    check("R11 reg0 zero", gotA, 32'h0);
    check("R11 reg3 intact", gotB, 32'h1234_5678);
  endtask

  task automatic branch(logic [4:0] rs, logic [4:0] rt, logic [15:0] imm, logic cond);
    loadIr(iFmt(6'h04, rs, rt, imm));
    aluSrcB = 2'd3; tick(); clr();
    aluSrcA = 1; aluSub = 1; pcWriteCond = cond; pcSrc = 2'd1; tick(); clr(); #1;
  endtask

  task automatic tBranch();
    branch(5'd3, 5'd3, 16'h0005, 1'b1);
    expPc = expPc + 32'd20;
    check("R6 taken fwd", memAddr, expPc);
    branch(5'd3, 5'd4, 16'h0005, 1'b1);
    check("R6 not taken", memAddr, expPc);
    branch(5'd3, 5'd3, 16'h0005, 1'b0);
    check("R6 no strobe", memAddr, expPc);
    branch(5'd3, 5'd3, 16'hFFFE, 1'b1);
    expPc = expPc - 32'd8;
    check("R6 taken back", memAddr, expPc);
  endtask

  task automatic tJump();
    readRegs(5'd3, 5'd4);
    check("R7 memWdata is B", memWdata, 32'h0000_1111);
    clr(); pcWrite = 1; pcSrc = 2'd1; tick(); clr(); #1;
    expPc = 32'h1234_5678;
    check("R5 pc from latch", memAddr, expPc);
    loadIr({6'h02, 26'h000_0010});
    pcWrite = 1; pcSrc = 2'd2; tick(); clr(); #1;
    expPc = 32'h1000_0040;
    check("R5 jump address", memAddr, expPc);
  endtask

  initial begin
    clr(); memRdata = 32'h0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tFetch();
    tImmHold();
    tRegs();
    tReg0();
    tBranch();
    tJump();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule